// File: doc/BRIEF.md
# Wide Register Access Collector

This block sits between a host bus that moves one 32-bit dword per access and a file of 128-bit control registers and 64-bit memory words. Its job is to make a wide register look atomic to the host. On the read side it takes a snapshot of a whole wide value into a read latch and answers the following dword reads of that register from the snapshot. On the write side it gathers dwords in a collector and sends one commit to the register file once the value is complete.

The host address space is split into two regions. Addresses with the top bit clear are control registers, grouped in windows of 0x2000 bytes, so the address is `page * 0x2000 + offset`. Addresses with the top bit set are 64-bit memory words. In every window, in-page offsets 0x400 and 0x420 are plain 32-bit registers with direct access. The 16-byte blocks at 0x830 and 0xA10 are write-only descriptor pointers. A write to their top dword commits at once, with any low dwords not already collected written as zero. Their other dwords are dropped if the collector is busy with another register. A write to the plain register at 0x420 in page 0 also empties the collector.

The register file is combinational on its read side. A read that this block starts returns its dword one cycle after the host request. Every commit is a one-cycle strobe that carries the unit address, 128 bits of data and a per-dword enable mask.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset, host_rvalid and rf_wr_en are low, the collector is empty and the read latch holds nothing, so the first read of any dword of a wide register reads the file.
- R2: A host read of dword 0 of a wide register asserts rf_rd_en with rf_rd_addr equal to the 16-byte aligned unit address in the same cycle, and returns dword 0 of that value on host_rdata with host_rvalid one cycle later.
- R3: A read of a non-zero dword of the register held in the read latch does not assert rf_rd_en and returns the latched dword, even when the file has changed since the snapshot.
- R4: A read of any dword of a register other than the latched one takes a new snapshot from the file and returns its dword.
- R5: Writes to a normal wide register are gathered in any order. Only the write that completes all four dwords produces one commit: rf_wr_en high for one cycle, one cycle after that write, with strobe 4'b1111, the unit address and dword i in bits 32*i+31:32*i.
- R6: Memory words (address bit 15 set) behave the same way with two dwords at +0 and +4. They are 8-byte aligned, use address bit 2 as the dword index, and commit with strobe 4'b0011 and the upper 64 bits zero.
- R7: A write to the top dword (+12) of a descriptor pointer always commits with strobe 4'b1111. Its low dwords hold the values collected for that same register, and zero where none were collected.
- R8: A write to a non-top dword of a descriptor pointer while the collector holds dwords of another register is dropped, and the collector is left unchanged.
- R9: A write to a normal wide register or memory word while the collector holds dwords of a different unit restarts the collector with only the new dword.
- R10: Pages are 0x2000 bytes apart. The descriptor pointers at in-page offsets 0x830 and 0xA10 are recognised in every page, and other 16-byte blocks there behave as normal wide registers.
- R11: A write to offset 0x420 in page 0 empties the collector. The same write in any other page leaves the collector alone.
- R12: Offsets 0x400 and 0x420 of every page are plain registers. A read fetches the file directly without touching the read latch. A write commits at once with a one-hot strobe for that dword lane, without touching the collector.
- R13: The collector is emptied after every commit, so a single later dword of the same register does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host byte address (low two bits ignored) |
| host_wdata | input | 32 | Host write dword |
| host_rdata | output | 32 | Read dword, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after the request |
| rf_rd_en | output | 1 | File read in this cycle |
| rf_rd_addr | output | 16 | Aligned unit address of the file read |
| rf_rd_data | input | 128 | Combinational file read value |
| rf_wr_en | output | 1 | One-cycle commit strobe |
| rf_wr_addr | output | 16 | Aligned unit address of the commit |
| rf_wr_data | output | 128 | Commit data, dword i in lane i |
| rf_wr_strb | output | 4 | Per-dword write enables of the commit |

## Verification
A wrong collector mask or address only becomes visible when the dword that should complete a register arrives. The commit then comes one dword too early, never comes, or carries a stale or non-zero lane. The bench therefore always follows a partial write with the completing write and compares the next cycle's strobe, address, data and mask. A stale or wrongly tagged read latch shows on the following higher-dword read as a missing or extra rf_rd_en in that same cycle and as wrong host_rdata one cycle later. Changing the file between the snapshot and the follow-up read is what makes a bad latch visible.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [1:0] {
        ACC_WIDE  = 2'd0,
        ACC_SPEC  = 2'd1,
        ACC_PLAIN = 2'd2,
        ACC_MEM   = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          IDXW       = 2,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned EVQ_OFS    = 32'h400,
    parameter int unsigned TMR_OFS    = 32'h420,
    parameter int unsigned SPC0_OFS   = 32'h830,
    parameter int unsigned SPC1_OFS   = 32'hA10
) (
    input  logic [AW-1:0]   addr,
    output acc_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic [AW-1:0]   unit_addr,
    output logic            top_dw,
    output logic            timer_pg0
);
    localparam int PGW = AW - 1 - PAGE_SHIFT;
    localparam logic [AW-1:0] WIDE_MASK = ~AW'((1 << (IDXW + 2)) - 1);
    localparam logic [AW-1:0] MEM_MASK  = ~AW'(7);
    localparam logic [PAGE_SHIFT-1:0] DW_MASK  = ~PAGE_SHIFT'(3);
    localparam logic [PAGE_SHIFT-1:0] BLK_MASK = PAGE_SHIFT'(WIDE_MASK);
    localparam logic [PAGE_SHIFT-1:0] EVQ_L  = PAGE_SHIFT'(EVQ_OFS);
    localparam logic [PAGE_SHIFT-1:0] TMR_L  = PAGE_SHIFT'(TMR_OFS);
    localparam logic [PAGE_SHIFT-1:0] SPC0_L = PAGE_SHIFT'(SPC0_OFS);
    localparam logic [PAGE_SHIFT-1:0] SPC1_L = PAGE_SHIFT'(SPC1_OFS);

    logic [PAGE_SHIFT-1:0] ofs;
    logic [PAGE_SHIFT-1:0] dw_ofs;
    logic [PAGE_SHIFT-1:0] blk_ofs;
    logic [PGW-1:0]        page;
    logic                  unused_low;

    assign unused_low = ^addr[1:0];

    always_comb begin
        ofs       = addr[PAGE_SHIFT-1:0];
        page      = addr[AW-2:PAGE_SHIFT];
        dw_ofs    = ofs & DW_MASK;
        blk_ofs   = ofs & BLK_MASK;
        kind      = ACC_WIDE;
        idx       = addr[2 +: IDXW];
        unit_addr = addr & WIDE_MASK;
        top_dw    = &addr[2 +: IDXW];
        timer_pg0 = 1'b0;
        if (addr[AW-1]) begin
            kind      = ACC_MEM;
            idx       = IDXW'(addr[2]);
            unit_addr = addr & MEM_MASK;
            top_dw    = addr[2];
        end else if (dw_ofs == EVQ_L || dw_ofs == TMR_L) begin
            kind      = ACC_PLAIN;
            timer_pg0 = (dw_ofs == TMR_L) && (page == '0);
        end else if (blk_ofs == SPC0_L || blk_ofs == SPC1_L) begin
            kind = ACC_SPEC;
        end
    end
endmodule

// File: rtl/wrc_rdlatch.sv
module wrc_rdlatch
    import wrc_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int WW   = 128,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_fire,
    input  acc_kind_e       kind,
    input  logic [IDXW-1:0] idx,
    input  logic [AW-1:0]   unit_addr,
    input  logic [WW-1:0]   rf_rd_data,
    output logic            rf_rd_en,
    output logic [DW-1:0]   rdata,
    output logic            rvalid
);
    typedef struct packed {
        logic          held;
        logic [AW-1:0] addr;
        logic [WW-1:0] data;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } lat_t;

    lat_t s_d, s_q;
    logic hit_d;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = rd_fire;
        rf_rd_en   = 1'b0;
        hit_d      = s_q.held && (s_q.addr == unit_addr);
        if (rd_fire) begin
            if (kind == ACC_PLAIN) begin
                rf_rd_en  = 1'b1;
                s_d.rdata = rf_rd_data[idx*DW +: DW];
            end else if (idx == '0 || !hit_d) begin
                rf_rd_en  = 1'b1;
                s_d.held  = 1'b1;
                s_d.addr  = unit_addr;
                s_d.data  = rf_rd_data;
                s_d.rdata = rf_rd_data[idx*DW +: DW];
            end else begin
                s_d.rdata = s_q.data[idx*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata  = s_q.rdata;
    assign rvalid = s_q.rvalid;
endmodule

// File: rtl/wrc_collect.sv
module wrc_collect
    import wrc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int WW      = 128,
    parameter int IDXW    = 2,
    parameter int MEM_NDW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_fire,
    input  acc_kind_e       kind,
    input  logic [IDXW-1:0] idx,
    input  logic [AW-1:0]   unit_addr,
    input  logic            top_dw,
    input  logic            timer_pg0,
    input  logic [DW-1:0]   wdata,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [WW-1:0]   wr_data,
    output logic [WW/DW-1:0] wr_strb
);
    localparam int NDW = WW / DW;
    localparam logic [NDW-1:0] FULL_WIDE = '1;
    localparam logic [NDW-1:0] FULL_MEM  = NDW'((1 << MEM_NDW) - 1);

    typedef struct packed {
        logic [NDW-1:0] mask;
        logic [AW-1:0]  addr;
        logic [WW-1:0]  data;
        logic           wen;
        logic [AW-1:0]  waddr;
        logic [WW-1:0]  wdata;
        logic [NDW-1:0] wstrb;
    } col_t;

    col_t s_d, s_q;
    logic           same_d;
    logic [NDW-1:0] held_mask_d;
    logic [WW-1:0]  held_data_d;
    logic [NDW-1:0] merged_mask_d;
    logic [WW-1:0]  merged_data_d;
    logic [NDW-1:0] lane_bit_d;
    logic [NDW-1:0] full_d;

    always_comb begin
        same_d      = (|s_q.mask) && (s_q.addr == unit_addr);
        held_mask_d = same_d ? s_q.mask : '0;
        for (int i = 0; i < NDW; i++) begin
            held_data_d[i*DW +: DW] = held_mask_d[i] ? s_q.data[i*DW +: DW] : '0;
        end
        lane_bit_d    = NDW'(1) << idx;
        merged_mask_d = held_mask_d | lane_bit_d;
        merged_data_d = held_data_d;
        merged_data_d[idx*DW +: DW] = wdata;
        full_d = (kind == ACC_MEM) ? FULL_MEM : FULL_WIDE;

        s_d     = s_q;
        s_d.wen = 1'b0;
        if (wr_fire) begin
            unique case (kind)
                ACC_PLAIN: begin
                    s_d.wen   = 1'b1;
                    s_d.waddr = unit_addr;
                    s_d.wstrb = lane_bit_d;
                    s_d.wdata = '0;
                    s_d.wdata[idx*DW +: DW] = wdata;
                    if (timer_pg0) s_d.mask = '0;
                end
                ACC_SPEC: begin
                    if (top_dw) begin
                        s_d.wen   = 1'b1;
                        s_d.waddr = unit_addr;
                        s_d.wstrb = FULL_WIDE;
                        s_d.wdata = merged_data_d;
                        s_d.mask  = '0;
                    end else if (!((|s_q.mask) && !same_d)) begin
                        s_d.mask = merged_mask_d;
                        s_d.addr = unit_addr;
                        s_d.data = merged_data_d;
                    end
                end
                default: begin
                    if ((merged_mask_d & full_d) == full_d) begin
                        s_d.wen   = 1'b1;
                        s_d.waddr = unit_addr;
                        s_d.wstrb = full_d;
                        s_d.wdata = merged_data_d;
                        s_d.mask  = '0;
                    end else begin
                        s_d.mask = merged_mask_d;
                        s_d.addr = unit_addr;
                        s_d.data = merged_data_d;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_en   = s_q.wen;
    assign wr_addr = s_q.waddr;
    assign wr_data = s_q.wdata;
    assign wr_strb = s_q.wstrb;
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 32,
    parameter int          WW         = 128,
    parameter int          MEM_NDW    = 2,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned EVQ_OFS    = 32'h400,
    parameter int unsigned TMR_OFS    = 32'h420,
    parameter int unsigned SPC0_OFS   = 32'h830,
    parameter int unsigned SPC1_OFS   = 32'hA10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_wr,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_rvalid,
    output logic            rf_rd_en,
    output logic [AW-1:0]   rf_rd_addr,
    input  logic [WW-1:0]   rf_rd_data,
    output logic            rf_wr_en,
    output logic [AW-1:0]   rf_wr_addr,
    output logic [WW-1:0]   rf_wr_data,
    output logic [WW/DW-1:0] rf_wr_strb
);
    localparam int NDW  = WW / DW;
    localparam int IDXW = $clog2(NDW);

    acc_kind_e       kind;
    logic [IDXW-1:0] idx;
    logic [AW-1:0]   unit_addr;
    logic            top_dw;
    logic            timer_pg0;
    logic            rd_fire;
    logic            wr_fire;

    assign rd_fire    = host_req && !host_wr;
    assign wr_fire    = host_req && host_wr;
    assign rf_rd_addr = unit_addr;

    wrc_decode #(
        .AW(AW), .IDXW(IDXW), .PAGE_SHIFT(PAGE_SHIFT),
        .EVQ_OFS(EVQ_OFS), .TMR_OFS(TMR_OFS),
        .SPC0_OFS(SPC0_OFS), .SPC1_OFS(SPC1_OFS)
    ) u_decode (
        .addr      (host_addr),
        .kind      (kind),
        .idx       (idx),
        .unit_addr (unit_addr),
        .top_dw    (top_dw),
        .timer_pg0 (timer_pg0)
    );

    wrc_rdlatch #(.AW(AW), .DW(DW), .WW(WW), .IDXW(IDXW)) u_rdlatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (rd_fire),
        .kind       (kind),
        .idx        (idx),
        .unit_addr  (unit_addr),
        .rf_rd_data (rf_rd_data),
        .rf_rd_en   (rf_rd_en),
        .rdata      (host_rdata),
        .rvalid     (host_rvalid)
    );

    wrc_collect #(.AW(AW), .DW(DW), .WW(WW), .IDXW(IDXW), .MEM_NDW(MEM_NDW)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .kind      (kind),
        .idx       (idx),
        .unit_addr (unit_addr),
        .top_dw    (top_dw),
        .timer_pg0 (timer_pg0),
        .wdata     (host_wdata),
        .wr_en     (rf_wr_en),
        .wr_addr   (rf_wr_addr),
        .wr_data   (rf_wr_data),
        .wr_strb   (rf_wr_strb)
    );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
    parameter int          AW         = 16,
    parameter int          DW         = 32,
    parameter int          WW         = 128,
    parameter int          MEM_NDW    = 2,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned EVQ_OFS    = 32'h400,
    parameter int unsigned TMR_OFS    = 32'h420,
    parameter int unsigned SPC0_OFS   = 32'h830,
    parameter int unsigned SPC1_OFS   = 32'hA10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_req,
    input logic            host_wr,
    input logic [AW-1:0]   host_addr,
    input logic            host_rvalid,
    input logic            rf_rd_en,
    input logic            rf_wr_en,
    input logic [WW/DW-1:0] rf_wr_strb
);
    localparam int NDW = WW / DW;
    localparam int TOP_OFS = WW / 8 - 4;
    localparam logic [NDW-1:0] MEM_FULL = NDW'((1 << MEM_NDW) - 1);
    localparam logic [PAGE_SHIFT-3:0] SPC0_TOP = (PAGE_SHIFT-2)'((SPC0_OFS + TOP_OFS) >> 2);
    localparam logic [PAGE_SHIFT-3:0] SPC1_TOP = (PAGE_SHIFT-2)'((SPC1_OFS + TOP_OFS) >> 2);
    localparam logic [PAGE_SHIFT-3:0] EVQ_DW   = (PAGE_SHIFT-2)'(EVQ_OFS >> 2);
    localparam logic [PAGE_SHIFT-3:0] TMR_DW   = (PAGE_SHIFT-2)'(TMR_OFS >> 2);

    logic csr_wr;
    logic spec_top_wr;
    logic plain_wr;

    assign csr_wr      = host_req && host_wr && !host_addr[AW-1];
    assign spec_top_wr = csr_wr && (host_addr[PAGE_SHIFT-1:2] == SPC0_TOP ||
                                    host_addr[PAGE_SHIFT-1:2] == SPC1_TOP);
    assign plain_wr    = csr_wr && (host_addr[PAGE_SHIFT-1:2] == EVQ_DW ||
                                    host_addr[PAGE_SHIFT-1:2] == TMR_DW);

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wr) |=> host_rvalid); // R2
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_wr) |=> !host_rvalid); // R1
    AST_FILE_READ_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> (host_req && !host_wr)); // R3
    AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && host_wr) |=> !rf_wr_en); // R5
    AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> ($countones(rf_wr_strb) == 1 || rf_wr_strb == '1 || rf_wr_strb == MEM_FULL)); // R6
    AST_SPECIAL_TOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        spec_top_wr |=> (rf_wr_en && rf_wr_strb == '1)); // R7
    AST_PLAIN_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        plain_wr |=> (rf_wr_en && $countones(rf_wr_strb) == 1)); // R12
endmodule

bind wide_reg_collector wrc_checker #(
    .AW(AW), .DW(DW), .WW(WW), .MEM_NDW(MEM_NDW), .PAGE_SHIFT(PAGE_SHIFT),
    .EVQ_OFS(EVQ_OFS), .TMR_OFS(TMR_OFS), .SPC0_OFS(SPC0_OFS), .SPC1_OFS(SPC1_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .rf_rd_en    (rf_rd_en),
    .rf_wr_en    (rf_wr_en),
    .rf_wr_strb  (rf_wr_strb)
);

// File: tb/wide_reg_collector_tb.sv
module wide_reg_collector_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_req = 1'b0;
    logic         host_wr = 1'b0;
    logic [15:0]  host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_rvalid;
    logic         rf_rd_en;
    logic [15:0]  rf_rd_addr;
    logic [127:0] rf_rd_data = '0;
    logic         rf_wr_en;
    logic [15:0]  rf_wr_addr;
    logic [127:0] rf_wr_data;
    logic [3:0]   rf_wr_strb;

    always #10 clk = ~clk;

    wide_reg_collector u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data), .rf_wr_strb(rf_wr_strb)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [127:0] fmem [int];
    bit           m_lvld = 1'b0;
    int           m_laddr = 0;
    logic [127:0] m_ldata = '0;
    int           m_cmask = 0;
    int           m_caddr = 0;
    logic [31:0]  m_cdw [4];

    function automatic logic [127:0] seedv(int a);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'h5A00_0000 ^ (32'(a) << 4) ^ 32'(i);
        return v;
    endfunction

    function automatic logic [127:0] frd(int a);
        if (fmem.exists(a)) return fmem[a];
        return seedv(a);
    endfunction

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic op(string tag, bit wr, int a, logic [31:0] d);
        int kind, idx, unit, top, tp0, dwo, blk, page, full;
        bit e_rden, e_wen;
        logic [31:0]  e_rdata;
        int           e_waddr;
        logic [127:0] e_wdata, cur;
        logic [3:0]   e_strb;
        // kinds: 0 wide, 1 descriptor pointer, 2 plain, 3 memory word
        page = (a >> 13) & 3;
        dwo  = (a & 'h1FFF) & ~3;
        blk  = (a & 'h1FFF) & ~15;
        tp0  = 0;
        if ((a >> 15) & 1) begin
            kind = 3; idx = (a >> 2) & 1; unit = a & ~7; top = idx;
        end else begin
            unit = a & ~15; idx = (a >> 2) & 3; top = (idx == 3);
            if (dwo == 'h400 || dwo == 'h420) kind = 2;
            else if (blk == 'h830 || blk == 'hA10) kind = 1;
            else kind = 0;
            tp0 = (kind == 2 && dwo == 'h420 && page == 0);
        end
        e_rden = 0; e_wen = 0; e_rdata = '0; e_waddr = 0; e_wdata = '0; e_strb = '0;
        if (!wr) begin
            if (kind == 2) begin
                e_rden = 1; cur = frd(unit); e_rdata = cur[idx*32 +: 32];
            end else if (idx == 0 || !m_lvld || m_laddr != unit) begin
                e_rden = 1; m_lvld = 1; m_laddr = unit; m_ldata = frd(unit);
                e_rdata = m_ldata[idx*32 +: 32];
            end else begin
                e_rdata = m_ldata[idx*32 +: 32];
            end
        end else if (kind == 2) begin
            e_wen = 1; e_waddr = unit; e_strb = 4'(1 << idx); e_wdata[idx*32 +: 32] = d;
            if (tp0) m_cmask = 0;
        end else if (kind == 1 && top) begin
            e_wen = 1; e_waddr = unit; e_strb = 4'hF;
            for (int i = 0; i < 3; i++)
                if (m_cmask != 0 && m_caddr == unit && ((m_cmask >> i) & 1)) e_wdata[i*32 +: 32] = m_cdw[i];
            e_wdata[96 +: 32] = d;
            m_cmask = 0;
        end else if (kind == 1 && m_cmask != 0 && m_caddr != unit) begin
            // dropped
        end else begin
            if (m_cmask == 0 || m_caddr != unit) begin
                m_cmask = 0; m_caddr = unit;
                for (int i = 0; i < 4; i++) m_cdw[i] = '0;
            end
            m_cmask |= (1 << idx); m_cdw[idx] = d;
            full = (kind == 3) ? 3 : 15;
            if (kind != 1 && (m_cmask & full) == full) begin
                e_wen = 1; e_waddr = unit; e_strb = 4'(full);
                for (int i = 0; i < 4; i++) if ((full >> i) & 1) e_wdata[i*32 +: 32] = m_cdw[i];
                m_cmask = 0;
            end
        end
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = 16'(a); host_wdata = d;
        #1;
        rf_rd_data = frd(int'(rf_rd_addr));
        chk(tag, "rf_rd_en", 128'(rf_rd_en), 128'(e_rden));
        if (e_rden) chk(tag, "rf_rd_addr", 128'(rf_rd_addr), 128'(unit));
        @(posedge clk); #1;
        host_req = 1'b0;
        chk(tag, "host_rvalid", 128'(host_rvalid), 128'(!wr));
        if (!wr) chk(tag, "host_rdata", 128'(host_rdata), 128'(e_rdata));
        chk(tag, "rf_wr_en", 128'(rf_wr_en), 128'(e_wen));
        if (e_wen) begin
            chk(tag, "rf_wr_addr", 128'(rf_wr_addr), 128'(e_waddr));
            chk(tag, "rf_wr_data", rf_wr_data, e_wdata);
            chk(tag, "rf_wr_strb", 128'(rf_wr_strb), 128'(e_strb));
            cur = frd(e_waddr);
            for (int i = 0; i < 4; i++) if (e_strb[i]) cur[i*32 +: 32] = e_wdata[i*32 +: 32];
            fmem[e_waddr] = cur;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "reset rvalid", 128'(host_rvalid), 128'(0));
        chk("R1", "reset wr_en", 128'(rf_wr_en), 128'(0));
        op("R1", 0, 'h0108, 0);                 // empty latch: file read
        op("R1", 1, 'h0104, 32'h1);              // empty collector: no commit
        // R2 / R3 / R4 read latch
        op("R2", 0, 'h0200, 0);
        op("R3", 0, 'h0204, 0);
        op("R3", 1, 'h0200, 32'hA0); op("R3", 1, 'h0204, 32'hA1);
        op("R3", 1, 'h0208, 32'hA2); op("R3", 1, 'h020C, 32'hA3);
        op("R3", 0, 'h0208, 0);                 // stale snapshot
        op("R3", 0, 'h020C, 0);
        op("R2", 0, 'h0200, 0);                 // fresh snapshot
        op("R4", 0, 'h0300, 0);
        op("R4", 0, 'h0108, 0);
        // R5 any order, R13 cleared after commit
        op("R5", 1, 'h050C, 32'hB3); op("R5", 1, 'h0504, 32'hB1);
        op("R5", 1, 'h0500, 32'hB0); op("R5", 1, 'h0508, 32'hB2);
        op("R13", 1, 'h0500, 32'hC0);
        op("R13", 1, 'h0504, 32'hC1); op("R13", 1, 'h0508, 32'hC2); op("R13", 1, 'h050C, 32'hC3);
        // R9 restart on a different unit
        op("R9", 1, 'h0600, 32'hD0); op("R9", 1, 'h0604, 32'hD1);
        op("R9", 1, 'h0700, 32'hE0); op("R9", 1, 'h0704, 32'hE1);
        op("R9", 1, 'h0708, 32'hE2); op("R9", 1, 'h070C, 32'hE3);
        op("R9", 1, 'h0608, 32'hD2); op("R9", 1, 'h060C, 32'hD3);
        op("R9", 1, 'h0600, 32'hD4); op("R9", 1, 'h0604, 32'hD5);
        // R6 memory words
        op("R6", 1, 'h8014, 32'hF1); op("R6", 1, 'h8010, 32'hF0);
        op("R6", 0, 'h8014, 0); op("R6", 0, 'h8010, 0); op("R6", 0, 'h8014, 0);
        op("R6", 1, 'h8020, 32'hF2); op("R6", 1, 'h8028, 32'hF3);
        // R7 descriptor pointer top dword
        op("R7", 1, 'h2834, 32'h11); op("R7", 1, 'h283C, 32'h13);
        op("R7", 1, 'h2A1C, 32'h23);
        // R8 drop on foreign pending data
        op("R8", 1, 'h0900, 32'h90);
        op("R8", 1, 'h2830, 32'h77);
        op("R8", 1, 'h0904, 32'h91); op("R8", 1, 'h0908, 32'h92); op("R8", 1, 'h090C, 32'h93);
        op("R8", 1, 'h283C, 32'h78);
        // R10 paging
        op("R10", 1, 'h6A10, 32'h31); op("R10", 1, 'h6A18, 32'h32); op("R10", 1, 'h6A1C, 32'h33);
        op("R10", 1, 'h483C, 32'h43);
        op("R10", 1, 'h284C, 32'h53);           // ordinary block in page 1: no commit
        op("R10", 1, 'h0A1C, 32'h63);
        // R11 timer clears collector only in page 0
        op("R11", 1, 'h1000, 32'h70); op("R11", 1, 'h1004, 32'h71);
        op("R11", 1, 'h0420, 32'h7F);
        op("R11", 1, 'h1008, 32'h72); op("R11", 1, 'h100C, 32'h73);
        op("R11", 1, 'h1100, 32'h80); op("R11", 1, 'h1104, 32'h81);
        op("R11", 1, 'h2420, 32'h8F);
        op("R11", 1, 'h1108, 32'h82); op("R11", 1, 'h110C, 32'h83);
        // R12 plain registers
        op("R12", 1, 'h0400, 32'h44);
        op("R12", 0, 'h0300, 0); op("R12", 0, 'h0400, 0); op("R12", 0, 'h2420, 0);
        op("R12", 0, 'h0304, 0);
        op("R12", 1, 'h0600, 32'h60); op("R12", 1, 'h0604, 32'h61);
        op("R12", 1, 'h4400, 32'h62);
        op("R12", 1, 'h0608, 32'h63); op("R12", 1, 'h060C, 32'h64);
        // mixed traffic over the R10 address map
        for (int n = 0; n < 600; n++) begin
            int base;
            int sel;
            sel = int'($urandom % 8);
            case (sel)
                0: base = 'h0100; 1: base = 'h2830; 2: base = 'h0A10; 3: base = 'h0400;
                4: base = 'h0420; 5: base = 'h8040; 6: base = 'h4200; default: base = 'h6A10;
            endcase
            op("R10", bit'($urandom % 2), base + 4 * int'($urandom % 4), $urandom);
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule